// File: doc/BRIEF.md
# Serialized Interrupt Slave Controller

This block is the peripheral end of a serialized interrupt scheme in which several devices share one line. The line is pulled high and is released by every device unless that device is actively driving it. All timing is counted in clocks of the bus clock. A host opens each interrupt cycle with a long low start pulse. A run of three-clock IRQ frames follows, one per slot. A short low stop pulse closes the cycle, and its length chooses the operating mode for the next cycle.

The block follows these frames by sampling the line on every clock. During its own assigned slot it reports the level of one selected interrupt request. It drives the line only in that slot, or for the single start-request pulse that quiet mode allows. In continuous mode only the host starts cycles. In quiet mode the block may start a cycle itself by pulling the line low for one clock when its request is active.

The integrating logic gives the block the sampled line, the request lines, a selector that picks one request, and the slot number. It receives a drive enable and a drive value, which feed an external tri-state pad.

Top module: `sirq_slave`

## Requirements
- R1: After reset the drive enable is 0, the block is idle and continuous mode is selected.
- R2: A start frame is accepted only when the line is sampled low on 4 to 8 consecutive clocks (START_MIN to START_MAX). A shorter or longer low run is ignored: no slot is driven in the frames that follow it.
- R3: Frame timing begins at the first clock edge that samples the line high after an accepted start. The clock that follows that edge is the sample phase of slot 0. Slot k occupies the three clocks that begin 3k clocks later, in the order sample, recovery, turnaround. Slots are numbered 0 to NUM_SLOTS-1.
- R4: In the sample phase of its own slot, the block drives 0 when the selected request is inactive, as sampled at the edge that begins the phase. It then drives 1 in the recovery phase and releases in the turnaround phase. An active request leaves the line released for the whole slot.
- R5: At every other time the drive enable is 0, except for the pulse of R6. A slot_num of NUM_SLOTS or more never drives.
- R6: In quiet mode, when the block is idle, the line is sampled high and the selected request is active, the block drives 0 for exactly one clock. It does not repeat this request until a start frame has been accepted.
- R7: In continuous mode the block never drives outside its slot, whatever the requests.
- R8: After the last slot, a stop low run of 2 clocks selects quiet mode and a run of 3 clocks selects continuous mode. A stop run of any other length leaves the mode unchanged.
- R9: The reported request is irq_req[irq_sel], which is active high by default. A selector value at or beyond NUM_IRQ counts as inactive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; the line is sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| serirq_i | input | 1 | Sampled level of the shared line |
| irq_req | input | NUM_IRQ | Interrupt request lines |
| irq_sel | input | SEL_W | Index of the request reported in the slot |
| slot_num | input | SLOT_W | Assigned IRQ slot number |
| serirq_oe | output | 1 | Drive enable for the shared line |
| serirq_o | output | 1 | Value driven when the enable is 1 |

## Verification
The assertions assume that irq_sel and slot_num stay constant from the start frame to the end of the stop frame. They also assume that no other agent pulls the line low while the block drives it high. The stimulus changes the selector and slot number only between cycles. Its host model drives low only during start and stop frames, and never during the frame window. A behavioural model of the line, built from integers and a frame position count, predicts the drive enable and value on every clock. Windowed counts of low and high drives, together with the cycle of the first low, test slot placement and the boundaries of the start and stop lengths.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_START = 3'd1,
      ST_SLOTS = 3'd2,
      ST_STOPW = 3'd3,
      ST_STOP  = 3'd4
   } sirq_state_t;

   typedef enum logic [1:0] {
      PH_SAMPLE = 2'd0,
      PH_RECOV  = 2'd1,
      PH_TURN   = 2'd2
   } sirq_phase_t;

endpackage

// File: rtl/sirq_req_select.sv
module sirq_req_select #(
   parameter int NUM_IRQ     = 4,
   parameter int SEL_W       = 2,
   parameter bit ACTIVE_HIGH = 1'b1
) (
   input  logic [NUM_IRQ-1:0] irq_req,
   input  logic [SEL_W-1:0]   irq_sel,
   output logic               req_active
);

   localparam logic [SEL_W:0] NUM_L = (SEL_W+1)'(NUM_IRQ);

   logic in_range;
   logic raw;

   assign in_range = ({1'b0, irq_sel} < NUM_L);

   always_comb begin
      raw = 1'b0;
      for (int i = 0; i < NUM_IRQ; i++) begin
         if ({1'b0, irq_sel} == (SEL_W+1)'(i)) raw = irq_req[i];
      end
   end

   // R9: polarity variant chosen at elaboration
   generate
      if (ACTIVE_HIGH) begin : g_pol_high
         assign req_active = in_range & raw;
      end else begin : g_pol_low
         assign req_active = in_range & ~raw;
      end
   endgenerate

endmodule

// File: rtl/sirq_frame_tracker.sv
module sirq_frame_tracker
   import sirq_pkg::*;
#(
   parameter int NUM_SLOTS  = 17,
   parameter int START_MIN  = 4,
   parameter int START_MAX  = 8,
   parameter int STOP_QUIET = 2,
   parameter int STOP_CONT  = 3,
   parameter int SLOT_W     = 5,
   parameter int RUN_W      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_i,
   output sirq_state_t       st_o,
   output sirq_state_t       nxt_st_o,
   output logic [SLOT_W-1:0] slot_o,
   output logic [SLOT_W-1:0] nxt_slot_o,
   output sirq_phase_t       phase_o,
   output sirq_phase_t       nxt_phase_o,
   output logic              quiet_o,
   output logic              start_ok_o
);

   localparam logic [RUN_W-1:0]  RUN_MAX   = {RUN_W{1'b1}};
   localparam logic [RUN_W-1:0]  RUN_ONE   = RUN_W'(1);
   localparam logic [RUN_W-1:0]  RUN_SMIN  = RUN_W'(START_MIN);
   localparam logic [RUN_W-1:0]  RUN_SMAX  = RUN_W'(START_MAX);
   localparam logic [RUN_W-1:0]  RUN_QUIET = RUN_W'(STOP_QUIET);
   localparam logic [RUN_W-1:0]  RUN_CONT  = RUN_W'(STOP_CONT);
   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS-1);

   sirq_state_t       st, nxt_st;
   sirq_phase_t       phase, nxt_phase;
   logic [SLOT_W-1:0] slot, nxt_slot;
   logic [RUN_W-1:0]  run, nxt_run;
   logic              quiet, nxt_quiet;
   logic              start_ok;

   always_comb begin
      nxt_st    = st;
      nxt_slot  = slot;
      nxt_phase = phase;
      nxt_run   = run;
      nxt_quiet = quiet;
      start_ok  = 1'b0;
      case (st)
         ST_IDLE: begin
            if (!line_i) begin
               nxt_st  = ST_START;
               nxt_run = RUN_ONE;
            end
         end
         ST_START: begin
            if (!line_i) begin
               nxt_run = (run == RUN_MAX) ? run : run + RUN_ONE;
            end else if (run >= RUN_SMIN && run <= RUN_SMAX) begin
               nxt_st    = ST_SLOTS;
               nxt_slot  = '0;
               nxt_phase = PH_SAMPLE;
               start_ok  = 1'b1;
            end else begin
               nxt_st = ST_IDLE;
            end
         end
         ST_SLOTS: begin
            case (phase)
               PH_SAMPLE: nxt_phase = PH_RECOV;
               PH_RECOV:  nxt_phase = PH_TURN;
               default: begin
                  nxt_phase = PH_SAMPLE;
                  if (slot == LAST_SLOT) nxt_st = ST_STOPW;
                  else                   nxt_slot = slot + SLOT_W'(1);
               end
            endcase
         end
         ST_STOPW: begin
            if (!line_i) begin
               nxt_st  = ST_STOP;
               nxt_run = RUN_ONE;
            end
         end
         ST_STOP: begin
            if (!line_i) begin
               nxt_run = (run == RUN_MAX) ? run : run + RUN_ONE;
            end else begin
               if (run == RUN_QUIET)     nxt_quiet = 1'b1;
               else if (run == RUN_CONT) nxt_quiet = 1'b0;
               nxt_st = ST_IDLE;
            end
         end
         default: nxt_st = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         slot  <= '0;
         phase <= PH_SAMPLE;
         run   <= '0;
         quiet <= 1'b0;
      end else begin
         st    <= nxt_st;
         slot  <= nxt_slot;
         phase <= nxt_phase;
         run   <= nxt_run;
         quiet <= nxt_quiet;
      end
   end

   assign st_o        = st;
   assign nxt_st_o    = nxt_st;
   assign slot_o      = slot;
   assign nxt_slot_o  = nxt_slot;
   assign phase_o     = phase;
   assign nxt_phase_o = nxt_phase;
   assign quiet_o     = quiet;
   assign start_ok_o  = start_ok;

   // R2
   slots_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SLOTS && $past(st) != ST_SLOTS) |->
         ($past(st) == ST_START && $past(run) >= RUN_SMIN && $past(run) <= RUN_SMAX));

   // R8
   mode_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(quiet) |-> ($past(st) == ST_STOP && st == ST_IDLE));

   // R3
   turn_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SLOTS && phase == PH_TURN && slot != LAST_SLOT) |=>
         (st == ST_SLOTS && phase == PH_SAMPLE && slot == $past(slot) + SLOT_W'(1)));

endmodule

// File: rtl/sirq_slot_driver.sv
module sirq_slot_driver
   import sirq_pkg::*;
#(
   parameter int SLOT_W = 5
) (
   input  sirq_state_t       nxt_st,
   input  logic [SLOT_W-1:0] nxt_slot,
   input  sirq_phase_t       nxt_phase,
   input  logic [SLOT_W-1:0] my_slot,
   input  logic              req_active,
   input  logic              cur_oe,
   input  logic              cur_val,
   output logic              slot_oe,
   output logic              slot_val
);

   logic mine_next;

   assign mine_next = (nxt_st == ST_SLOTS) && (nxt_slot == my_slot);

   always_comb begin
      slot_oe  = 1'b0;
      slot_val = 1'b0;
      if (mine_next && nxt_phase == PH_SAMPLE && !req_active) begin
         slot_oe  = 1'b1;
         slot_val = 1'b0;
      end else if (mine_next && nxt_phase == PH_RECOV && cur_oe && !cur_val) begin
         slot_oe  = 1'b1;
         slot_val = 1'b1;
      end
   end

endmodule

// File: rtl/sirq_start_request.sv
module sirq_start_request
   import sirq_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  sirq_state_t st,
   input  logic        line_i,
   input  logic        quiet,
   input  logic        req_active,
   input  logic        start_ok,
   output logic        fire
);

   logic used;

   assign fire = (st == ST_IDLE) && line_i && quiet && req_active && !used;

   always_ff @(posedge clk) begin
      if (!rst_n)        used <= 1'b0;
      else if (start_ok) used <= 1'b0;
      else if (fire)     used <= 1'b1;
   end

   // R6
   single_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !fire);

endmodule

// File: rtl/sirq_slave.sv
module sirq_slave
   import sirq_pkg::*;
#(
   parameter int NUM_IRQ         = 4,
   parameter int NUM_SLOTS       = 17,
   parameter int START_MIN       = 4,
   parameter int START_MAX       = 8,
   parameter int STOP_QUIET      = 2,
   parameter int STOP_CONT       = 3,
   parameter bit REQ_ACTIVE_HIGH = 1'b1,
   localparam int SEL_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1,
   localparam int SLOT_W = $clog2(NUM_SLOTS + 1),
   localparam int RUN_W  = $clog2(START_MAX + 2)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               serirq_i,
   input  logic [NUM_IRQ-1:0] irq_req,
   input  logic [SEL_W-1:0]   irq_sel,
   input  logic [SLOT_W-1:0]  slot_num,
   output logic               serirq_oe,
   output logic               serirq_o
);

   generate
      if (NUM_IRQ < 1) begin : g_bad_irq
         $error("sirq_slave: NUM_IRQ must be at least 1");
      end
      if (NUM_SLOTS < 1) begin : g_bad_slots
         $error("sirq_slave: NUM_SLOTS must be at least 1");
      end
      if (START_MIN < 2 || START_MIN > START_MAX) begin : g_bad_start
         $error("sirq_slave: start window must satisfy 2 <= START_MIN <= START_MAX");
      end
      if (STOP_QUIET < 1 || STOP_CONT < 1 || STOP_QUIET == STOP_CONT) begin : g_bad_stop
         $error("sirq_slave: stop lengths must be positive and distinct");
      end
      if (STOP_QUIET > START_MAX || STOP_CONT > START_MAX) begin : g_bad_stop_w
         $error("sirq_slave: stop lengths must fit the run counter");
      end
   endgenerate

   sirq_state_t       st, nxt_st;
   sirq_phase_t       phase, nxt_phase;
   logic [SLOT_W-1:0] slot, nxt_slot;
   logic              quiet, start_ok;
   logic              req_active;
   logic              slot_oe, slot_val, fire;
   logic              oe_q, val_q;

   sirq_req_select #(
      .NUM_IRQ     (NUM_IRQ),
      .SEL_W       (SEL_W),
      .ACTIVE_HIGH (REQ_ACTIVE_HIGH)
   ) i_sel (
      .irq_req    (irq_req),
      .irq_sel    (irq_sel),
      .req_active (req_active)
   );

   sirq_frame_tracker #(
      .NUM_SLOTS  (NUM_SLOTS),
      .START_MIN  (START_MIN),
      .START_MAX  (START_MAX),
      .STOP_QUIET (STOP_QUIET),
      .STOP_CONT  (STOP_CONT),
      .SLOT_W     (SLOT_W),
      .RUN_W      (RUN_W)
   ) i_track (
      .clk         (clk),
      .rst_n       (rst_n),
      .line_i      (serirq_i),
      .st_o        (st),
      .nxt_st_o    (nxt_st),
      .slot_o      (slot),
      .nxt_slot_o  (nxt_slot),
      .phase_o     (phase),
      .nxt_phase_o (nxt_phase),
      .quiet_o     (quiet),
      .start_ok_o  (start_ok)
   );

   sirq_slot_driver #(
      .SLOT_W (SLOT_W)
   ) i_drv (
      .nxt_st     (nxt_st),
      .nxt_slot   (nxt_slot),
      .nxt_phase  (nxt_phase),
      .my_slot    (slot_num),
      .req_active (req_active),
      .cur_oe     (oe_q),
      .cur_val    (val_q),
      .slot_oe    (slot_oe),
      .slot_val   (slot_val)
   );

   sirq_start_request i_req (
      .clk        (clk),
      .rst_n      (rst_n),
      .st         (st),
      .line_i     (serirq_i),
      .quiet      (quiet),
      .req_active (req_active),
      .start_ok   (start_ok),
      .fire       (fire)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         oe_q  <= 1'b0;
         val_q <= 1'b0;
      end else begin
         oe_q  <= slot_oe | fire;
         val_q <= slot_oe & slot_val;
      end
   end

   assign serirq_oe = oe_q;
   assign serirq_o  = val_q;

   // R5
   only_own_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      serirq_oe |-> ((st == ST_SLOTS && slot == slot_num && phase != PH_TURN) ||
                     (st == ST_IDLE && quiet && !serirq_o)));

   // R4
   low_then_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (serirq_oe && !serirq_o && st == ST_SLOTS) |=> (serirq_oe && serirq_o));

   // R4
   high_then_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (serirq_oe && serirq_o) |=> !serirq_oe);

   // R6
   pulse_one_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (serirq_oe && st == ST_IDLE) |=> !serirq_oe);

   // R7
   no_cont_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_SLOTS && !quiet) |-> !serirq_oe);

endmodule

// File: tb/test_sirq_slave.sv
module test_sirq_slave;

   localparam int CLK_PERIOD = 10;
   localparam int NUM_IRQ    = 4;
   localparam int NUM_SLOTS  = 17;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_low = 1'b0;
   logic [3:0] irq_req = '0;
   logic [1:0] irq_sel = '0;
   logic [4:0] slot_num = '0;
   logic       dev_oe, dev_o;
   logic       line;

   assign line = host_low ? 1'b0 : (dev_oe ? dev_o : 1'b1);

   always #(CLK_PERIOD/2) clk = ~clk;

   sirq_slave #(.NUM_IRQ(NUM_IRQ), .NUM_SLOTS(NUM_SLOTS)) i_sirq_slave (
      .clk       (clk),
      .rst_n     (rst_n),
      .serirq_i  (line),
      .irq_req   (irq_req),
      .irq_sel   (irq_sel),
      .slot_num  (slot_num),
      .serirq_oe (dev_oe),
      .serirq_o  (dev_o)
   );

   int    checks = 0, fails = 0, cyc = 0;
   int    low_tot = 0, high_tot = 0, last_low_cyc = -1;
   bit    finished = 1'b0;

   // behavioural reference: kind 0 idle, 1 start, 2 frames, 3 await stop, 4 stop
   int    m_kind = 0, m_run = 0, m_pos = 0;
   bit    m_quiet = 1'b0, m_used = 1'b0, e_oe = 1'b0, e_out = 1'b0;
   string e_tag = "R1";

   always @(posedge clk) cyc = cyc + 1;

   always @(posedge clk) begin : ref_model
      bit l, p, was_low, n_oe, n_out;
      string tg;
      if (!rst_n) begin
         m_kind = 0; m_run = 0; m_pos = 0; m_quiet = 0; m_used = 0;
         e_oe = 0; e_out = 0; e_tag = "R1";
      end else begin
         l = line;
         p = irq_req[irq_sel];
         was_low = e_oe && !e_out;
         n_oe = 0; n_out = 0; tg = "R5";
         case (m_kind)
            0: begin
               if (!l) begin m_kind = 1; m_run = 1; end
               else if (m_quiet && p && !m_used) begin
                  n_oe = 1; m_used = 1; tg = "R6";
               end else if (!m_quiet) tg = "R7";
            end
            1: begin
               if (!l) m_run++;
               else if (m_run >= 4 && m_run <= 8) begin
                  m_kind = 2; m_pos = -1; m_used = 0; tg = "R2";
               end else begin
                  m_kind = 0; tg = "R2";
               end
            end
            2: ;
            3: if (!l) begin m_kind = 4; m_run = 1; end
            default: begin
               if (!l) m_run++;
               else begin
                  if (m_run == 2) m_quiet = 1;
                  else if (m_run == 3) m_quiet = 0;
                  m_kind = 0; tg = "R8";
               end
            end
         endcase
         if (m_kind == 2) begin
            m_pos++;
            if (m_pos == 3*NUM_SLOTS) m_kind = 3;
            else if (m_pos / 3 == int'(slot_num)) begin
               tg = "R4";
               if (m_pos % 3 == 0 && !p) n_oe = 1;
               else if (m_pos % 3 == 1 && was_low) begin n_oe = 1; n_out = 1; end
            end
         end
         e_oe = n_oe; e_out = n_out; e_tag = tg;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         checks++;
         if (dev_oe !== e_oe || (e_oe && dev_o !== e_out)) begin
            fails++;
            $display("FAIL %s per-cycle drive at cycle %0d: oe=%0b val=%0b expected oe=%0b val=%0b",
                     e_tag, cyc, dev_oe, dev_o, e_oe, e_out);
         end
         if (dev_oe && !dev_o) begin low_tot++; last_low_cyc = cyc; end
         if (dev_oe && dev_o) high_tot++;
      end
   end

   task automatic check(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic host_pulse(input int n);
      host_low = 1'b1;
      idle(n);
      host_low = 1'b0;
   endtask

   int rel_cyc = 0;

   task automatic run_cycle(input int s, input int t);
      host_pulse(s);
      rel_cyc = cyc;
      idle(3*NUM_SLOTS + 2);
      host_pulse(t);
      idle(4);
   endtask

   int l0, h0;
   task automatic mark();
      l0 = low_tot; h0 = high_tot;
   endtask

   initial begin
      idle(3);
      check("R1", "drive enable in reset", int'(dev_oe), 0);
      rst_n = 1'b1;
      idle(1);
      check("R1", "drive enable after reset", int'(dev_oe), 0);

      // continuous after reset: pending request gives no drive
      irq_req = 4'hF; mark(); idle(20);
      check("R7", "lows while continuous and pending", low_tot - l0, 0);

      // own slot 2, request inactive, stop 2 -> quiet
      irq_req = 4'h0; slot_num = 5'd2; mark(); run_cycle(6, 2);
      check("R4", "lows in own slot", low_tot - l0, 1);
      check("R4", "recovery highs", high_tot - h0, 1);
      check("R3", "cycle of slot 2 sample", last_low_cyc, rel_cyc + 1 + 3*2);

      // quiet, inactive: no request
      mark(); idle(10);
      check("R6", "lows quiet without pending", low_tot - l0, 0);

      // quiet, active: single request pulse, not repeated
      irq_req = 4'hF; mark(); idle(12);
      check("R6", "request pulses", low_tot - l0, 1);
      check("R6", "request high drives", high_tot - h0, 0);
      mark(); run_cycle(5, 3);
      check("R4", "lows with active request in slot", low_tot - l0, 0);
      mark(); idle(10);
      check("R8", "lows after stop 3 (continuous)", low_tot - l0, 0);

      // start too short, then longest valid, stop 5 keeps continuous
      irq_req = 4'h0; mark(); host_pulse(3); idle(3*NUM_SLOTS + 5);
      check("R2", "lows after 3-clock start", low_tot - l0, 0);
      mark(); run_cycle(8, 5);
      check("R2", "lows after 8-clock start", low_tot - l0, 1);
      irq_req = 4'hF; mark(); idle(10);
      check("R8", "lows after stop 5 kept continuous", low_tot - l0, 0);

      // start too long, then shortest valid, stop 2 -> quiet
      irq_req = 4'h0; mark(); host_pulse(9); idle(3*NUM_SLOTS + 5);
      check("R2", "lows after 9-clock start", low_tot - l0, 0);
      mark(); run_cycle(4, 2);
      check("R2", "lows after 4-clock start", low_tot - l0, 1);
      mark(); run_cycle(6, 4);
      irq_req = 4'hF; idle(10);
      check("R8", "lows with stop 4 kept quiet (slot + request)", low_tot - l0, 2);
      mark(); run_cycle(6, 3);
      check("R8", "lows in cycle returning to continuous", low_tot - l0, 0);

      // selector picks the reported line
      irq_req = 4'b0100; irq_sel = 2'd1; mark(); run_cycle(6, 6);
      check("R9", "lows with selected line inactive", low_tot - l0, 1);
      irq_sel = 2'd2; mark(); run_cycle(6, 6);
      check("R9", "lows with selected line active", low_tot - l0, 0);

      // last slot and out-of-range slot
      irq_req = 4'h0; slot_num = 5'd16; mark(); run_cycle(6, 6);
      check("R3", "cycle of last slot sample", last_low_cyc, rel_cyc + 1 + 3*16);
      check("R3", "last slot high drives", high_tot - h0, 1);
      slot_num = 5'd17; mark(); run_cycle(6, 6);
      check("R5", "lows with out-of-range slot", low_tot - l0, 0);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         finished = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog: run did not complete");
         $display("  [TB] %0d tests run, %0d failed", checks, fails);
         $finish;
      end
   end

endmodule